// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external host read and write a bank of 64 byte-wide registers over a four-signal serial link framed by an active-low select. Each frame opens with an 8-bit header. The header holds a direction flag, an address-step flag and a 6-bit register address. One or more 8-bit data blocks follow, for as long as the select stays low. The link signals are oversampled by the system clock through a short synchronizer. Every frame decision is therefore taken in the system clock domain.

Read data leaves in one of two ways. It can go out on a dedicated output pin. In three-wire mode it goes instead on the output half of a shared data pin, with its own output enable. A range of registers is reserved for values supplied by other on-chip logic. The host cannot change them, and a parallel update port writes them.

Top module: `spi_rs_top`

## Requirements
- R1: Header bit order after select falls: bit 0 is the direction (1 = read, 0 = write), bit 1 is the address-step flag, and bits 2..7 are the register address, most significant bit first. Data lines change on the falling serial clock edge, are sampled on the rising edge, and the clock idles high.
- R2: A single write takes 16 clock periods. The data byte is committed to the addressed register only once all 8 of its bits have been received.
- R3: In a read, the data byte of the current address is driven most significant bit first, starting at the first falling edge of frame bit 8. No output enable is active during the header or during any write frame.
- R4: With the step flag at 1, the address advances by one after every data block and wraps from 63 to 0.
- R5: With the step flag at 0, every data block of a burst uses the same address, so the last written byte wins and repeated reads return the same value.
- R6: Registers 0x28 to 0x2F are read-only to the host. Serial writes to them leave their contents unchanged.
- R7: The parallel update port writes only the read-only registers. An update aimed at any other address is ignored.
- R8: Raising select in the middle of a byte discards that partial byte, turns off the output enable, and restarts header reception for the next frame.
- R9: With the three-wire mode input at 1, read data leaves on the shared pin output with the shared enable high and the dedicated enable low. With the mode input at 0, the two enables swap roles.
- R10: After reset every register reads 0x00 and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Frame select, active low |
| sck | input | 1 | Serial clock from the host, idles high |
| sdi | input | 1 | Serial data in (input half of the shared pin in three-wire mode) |
| wire3 | input | 1 | 1 selects three-wire half-duplex operation |
| sdo | output | 1 | Dedicated serial data out |
| sdo_oe | output | 1 | Enable for the dedicated output |
| sio_out | output | 1 | Output half of the shared data pin |
| sio_oe | output | 1 | Enable for the shared data pin |
| upd_we | input | 1 | Parallel update strobe |
| upd_addr | input | 6 | Parallel update address |
| upd_data | input | 8 | Parallel update data |

## Verification
Single-byte accesses with alternating bit patterns such as 0xA5 and 0x5A show that the header fields are decoded in the right order and that data is shifted most significant bit first. A three-byte stepped burst, a two-byte fixed-address burst and a burst that starts at address 63 separate the increment, hold and wrap behaviours. In a fixed burst only the last byte survives, and in a wrapped burst the second byte lands in register 0. Writes aimed at the reserved range, updates aimed at ordinary registers, and frames cut off after 5 data bits show which path the block ignores. Repeating a burst read in three-wire mode shows that only the enable pair changes between the two pin arrangements.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
   typedef enum logic {
      DIR_WR = 1'b0,
      DIR_RD = 1'b1
   } dir_e;

   // Header layout: direction in the MSB, step flag next, address below.
   function automatic logic hdr_dir_bit(input logic [7:0] b);
      return b[7];
   endfunction

   function automatic logic hdr_step_bit(input logic [7:0] b);
      return b[6];
   endfunction
endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [31:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      assert (STAGES >= 2) else $error("spi_rs_sync: STAGES must be at least 2");
      assert (WIDTH >= 1 && WIDTH <= 32) else $error("spi_rs_sync: WIDTH out of range");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[s] <= RST_VAL[WIDTH-1:0];
            end else begin
               if (s == 0) stage_q[s] <= d;
               else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rs_frame.sv
module spi_rs_frame
   import spi_rs_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              sck_s,
   input  logic              sdi_s,
   input  logic [DATA_W-1:0] rd_byte,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              tx_bit,
   output logic              drive
);
   localparam int               CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

   initial begin
      assert (DATA_W == ADDR_W + 2) else $error("spi_rs_frame: header must fill one data block");
      assert ((1 << CNT_W) == DATA_W) else $error("spi_rs_frame: DATA_W must be a power of two");
   end

   logic              sck_q;
   logic              rise, fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic              in_hdr;
   dir_e              dir;
   logic              step;
   logic [DATA_W-1:0] shin, shout;
   logic              load_pend;
   logic [DATA_W-1:0] byte_in;

   assign rise    = sck_s & ~sck_q & ~cs_n_s;
   assign fall    = ~sck_s & sck_q & ~cs_n_s;
   assign byte_in = {shin[DATA_W-2:0], sdi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q     <= 1'b1;
         bit_cnt   <= '0;
         in_hdr    <= 1'b1;
         dir       <= DIR_WR;
         step      <= 1'b0;
         cur_addr  <= '0;
         shin      <= '0;
         shout     <= '0;
         load_pend <= 1'b0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         tx_bit    <= 1'b0;
         drive     <= 1'b0;
      end else begin
         sck_q <= sck_s;
         wr_en <= 1'b0;
         if (cs_n_s) begin
            bit_cnt   <= '0;
            in_hdr    <= 1'b1;
            load_pend <= 1'b0;
            drive     <= 1'b0;
         end else begin
            if (rise) begin
               shin    <= byte_in;
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == LAST) begin
                  if (in_hdr) begin
                     in_hdr    <= 1'b0;
                     dir       <= dir_e'(hdr_dir_bit(byte_in));
                     step      <= hdr_step_bit(byte_in);
                     cur_addr  <= byte_in[ADDR_W-1:0];
                     load_pend <= hdr_dir_bit(byte_in);
                  end else begin
                     if (dir == DIR_WR) begin
                        wr_en   <= 1'b1;
                        wr_addr <= cur_addr;
                        wr_data <= byte_in;
                     end else begin
                        load_pend <= 1'b1;
                     end
                     if (step) cur_addr <= cur_addr + 1'b1;
                  end
               end
            end
            if (fall) begin
               if (load_pend) begin
                  tx_bit    <= rd_byte[DATA_W-1];
                  shout     <= {rd_byte[DATA_W-2:0], 1'b0};
                  load_pend <= 1'b0;
                  drive     <= 1'b1;
               end else begin
                  tx_bit <= shout[DATA_W-1];
                  shout  <= {shout[DATA_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   // R3
   drive_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> (dir == DIR_RD) && !in_hdr);

   // R4
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && bit_cnt == LAST && !in_hdr && step) |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1));

   // R5
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && bit_cnt == LAST && !in_hdr && !step) |=> $stable(cur_addr));

   // R8
   release_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !drive && bit_cnt == '0);
endmodule

// File: rtl/spi_rs_regs.sv
module spi_rs_regs #(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 8,
   parameter int RO_BASE  = 40,
   parameter int RO_COUNT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_we,
   input  logic [ADDR_W-1:0] spi_addr,
   input  logic [DATA_W-1:0] spi_wdata,
   input  logic              upd_we,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic [DATA_W-1:0] upd_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   initial begin
      assert (RO_BASE >= 0 && RO_BASE + RO_COUNT <= DEPTH)
         else $error("spi_rs_regs: read-only range outside the bank");
   end

   function automatic logic is_ro(input logic [ADDR_W-1:0] a);
      return (int'(a) >= RO_BASE) && (int'(a) < RO_BASE + RO_COUNT);
   endfunction

   logic [DEPTH-1:0][DATA_W-1:0] bank;

   genvar i;
   generate
      for (i = 0; i < DEPTH; i++) begin : g_reg
         logic [DATA_W-1:0] q;
         if (i >= RO_BASE && i < RO_BASE + RO_COUNT) begin : g_ro
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                     q <= '0;
               else if (upd_we && upd_addr == ADDR_W'(i))      q <= upd_data;
            end
         end else begin : g_rw
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                     q <= '0;
               else if (spi_we && spi_addr == ADDR_W'(i))      q <= spi_wdata;
            end
         end
         assign bank[i] = q;
      end
   endgenerate

   assign rd_data = bank[rd_addr];

   // R2
   commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_we && !is_ro(spi_addr)) |=> bank[$past(spi_addr)] == $past(spi_wdata));

   // R6
   ro_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_we && is_ro(spi_addr) && !upd_we) |=> bank[$past(spi_addr)] == $past(bank[spi_addr]));

   // R7
   upd_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_we && !is_ro(upd_addr) && !spi_we) |=> bank[$past(upd_addr)] == $past(bank[upd_addr]));
endmodule

// File: rtl/spi_rs_top.sv
module spi_rs_top #(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int RO_BASE     = 40,
   parameter int RO_COUNT    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              sdi,
   input  logic              wire3,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              sio_out,
   output logic              sio_oe,
   input  logic              upd_we,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic [DATA_W-1:0] upd_data
);
   logic [2:0]        raw, synced;
   logic              cs_n_s, sck_s, sdi_s;
   logic [ADDR_W-1:0] cur_addr, wr_addr;
   logic              wr_en, tx_bit, drive;
   logic [DATA_W-1:0] wr_data, rd_byte;

   assign raw = {cs_n, sck, sdi};

   spi_rs_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(32'h7)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw),
      .q    (synced)
   );

   assign {cs_n_s, sck_s, sdi_s} = synced;

   spi_rs_frame #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n_s  (cs_n_s),
      .sck_s   (sck_s),
      .sdi_s   (sdi_s),
      .rd_byte (rd_byte),
      .cur_addr(cur_addr),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .tx_bit  (tx_bit),
      .drive   (drive)
   );

   spi_rs_regs #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .RO_BASE (RO_BASE),
      .RO_COUNT(RO_COUNT)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_we   (wr_en),
      .spi_addr (wr_addr),
      .spi_wdata(wr_data),
      .upd_we   (upd_we),
      .upd_addr (upd_addr),
      .upd_data (upd_data),
      .rd_addr  (cur_addr),
      .rd_data  (rd_byte)
   );

   assign sdo     = tx_bit;
   assign sio_out = tx_bit;
   assign sdo_oe  = drive & ~wire3;
   assign sio_oe  = drive &  wire3;

   // R9
   pin_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sdo_oe && sio_oe));

   // R9
   shared_pin_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sio_oe |-> wire3);

   // R8
   idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !(sdo_oe || sio_oe));
endmodule

// File: tb/spi_rs_top_bench.sv
module spi_rs_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, sck = 1'b1, sdi = 1'b1, wire3 = 1'b0;
   logic       sdo, sdo_oe, sio_out, sio_oe;
   logic       upd_we = 1'b0;
   logic [5:0] upd_addr = '0;
   logic [7:0] upd_data = '0;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [7:0] model [64];
   logic [7:0] wbuf [8];
   logic [7:0] exp_q [$];
   string      req_tag = "R3";
   bit         mon_arm = 0;
   bit         idle_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_rs_top u_spi_rs_top (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .wire3(wire3),
      .sdo(sdo), .sdo_oe(sdo_oe), .sio_out(sio_out), .sio_oe(sio_oe),
      .upd_we(upd_we), .upd_addr(upd_addr), .upd_data(upd_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit ro_addr(input logic [5:0] a);
      return a >= 6'h28 && a <= 6'h2F;
   endfunction

   // Monitor: assembles read bytes on rising edges and compares with the queue.
   int         mon_cnt = 0;
   logic [7:0] mon_byte = '0;
   bit         mon_pin_bad = 0;
   always @(posedge sck) begin
      if (mon_arm) begin
         mon_byte = {mon_byte[6:0], (wire3 ? sio_out : sdo)};
         if (wire3 ? !(sio_oe && !sdo_oe) : !(sdo_oe && !sio_oe)) mon_pin_bad = 1;
         mon_cnt++;
         if (mon_cnt == 8) begin
            mon_cnt = 0;
            if (exp_q.size() == 0) begin
               chk(req_tag, {24'h0, mon_byte}, 32'hDEAD);
            end else begin
               chk(req_tag, {24'h0, mon_byte}, {24'h0, exp_q.pop_front()});
            end
            // R9 enable pair during this byte
            chk("R9", {31'h0, mon_pin_bad}, 32'h0);
            mon_pin_bad = 0;
         end
      end
   end

   task automatic send_bit(input logic b, input bit want_idle);
      @(negedge clk);
      sck = 1'b0;
      sdi = b;
      repeat (HALF) @(negedge clk);
      if (want_idle && (sdo_oe || sio_oe)) idle_bad = 1;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit want_idle);
      for (int i = 7; i >= 0; i--) send_bit(b[i], want_idle);
   endtask

   task automatic frame_start();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic frame_end();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      sdi  = 1'b1;
      repeat (3*HALF) @(negedge clk);
   endtask

   // R1 header: {dir, step, addr[5:0]}
   task automatic spi_write(input bit step, input logic [5:0] a, input int n);
      logic [5:0] ad = a;
      idle_bad = 0;
      frame_start();
      send_byte({1'b0, step, a}, 1);
      for (int k = 0; k < n; k++) begin
         send_byte(wbuf[k], 1);
         if (!ro_addr(ad)) model[ad] = wbuf[k];
         if (step) ad = ad + 1'b1;
      end
      frame_end();
      // R3 no enable during header or write data
      chk("R3", {31'h0, idle_bad}, 32'h0);
   endtask

   task automatic spi_read(input bit step, input logic [5:0] a, input int n, input string req);
      logic [5:0] ad = a;
      idle_bad = 0;
      req_tag = req;
      frame_start();
      send_byte({1'b1, step, a}, 1);
      chk("R3", {31'h0, idle_bad}, 32'h0);
      for (int k = 0; k < n; k++) begin
         exp_q.push_back(model[ad]);
         if (step) ad = ad + 1'b1;
         mon_arm = 1;
         send_byte(8'h00, 0);
         mon_arm = 0;
      end
      frame_end();
      chk(req, exp_q.size(), 0);
   endtask

   task automatic upd(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      upd_we = 1'b1; upd_addr = a; upd_data = d;
      @(negedge clk);
      upd_we = 1'b0;
      if (ro_addr(a)) model[a] = d;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) model[i] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R10 reset state
      chk("R10", {30'h0, sdo_oe, sio_oe}, 32'h0);
      spi_read(0, 6'h2A, 1, "R10");

      // R1 R2 single write and read, alternating pattern
      wbuf[0] = 8'hA5;
      spi_write(0, 6'h05, 1);
      spi_read(0, 6'h05, 1, "R2");

      // R4 stepped burst
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      spi_write(1, 6'h10, 3);
      spi_read(1, 6'h10, 3, "R4");

      // R5 fixed-address burst: last byte wins, neighbour untouched
      wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
      spi_write(0, 6'h20, 2);
      spi_read(0, 6'h20, 2, "R5");
      spi_read(0, 6'h21, 1, "R5");

      // R4 wrap from 63 to 0
      wbuf[0] = 8'h77; wbuf[1] = 8'h88;
      spi_write(1, 6'h3F, 2);
      spi_read(1, 6'h3F, 2, "R4");

      // R7 update port: reserved register takes it, ordinary one ignores it
      upd(6'h28, 8'h9C);
      upd(6'h05, 8'hFF);
      spi_read(0, 6'h28, 1, "R7");
      spi_read(0, 6'h05, 1, "R7");

      // R6 host write to reserved range ignored
      wbuf[0] = 8'h00; wbuf[1] = 8'h12;
      spi_write(1, 6'h28, 2);
      spi_read(1, 6'h28, 2, "R6");

      // R8 write cut after 5 data bits
      frame_start();
      send_byte({2'b00, 6'h05}, 1);
      for (int i = 0; i < 5; i++) send_bit(1'b0, 1);
      frame_end();
      spi_read(0, 6'h05, 1, "R8");

      // R8 read cut mid-byte: enable on before, off after
      frame_start();
      send_byte({2'b10, 6'h10}, 1);
      for (int i = 0; i < 3; i++) send_bit(1'b0, 0);
      chk("R8", {31'h0, sdo_oe}, 32'h1);
      frame_end();
      chk("R8", {30'h0, sdo_oe, sio_oe}, 32'h0);
      spi_read(0, 6'h11, 1, "R8");

      // R9 three-wire mode
      wire3 = 1'b1;
      repeat (2) @(negedge clk);
      spi_read(1, 6'h10, 3, "R9");
      wbuf[0] = 8'h3C;
      spi_write(0, 6'h06, 1);
      spi_read(0, 6'h06, 1, "R9");
      wire3 = 1'b0;

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule